// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a direct-mapped cache between a processor word port and a lower-level memory that moves whole four-word lines. A byte address is split into four fields. The highest bits form the tag. Next comes the line index, then the word-in-line select, and the lowest two bits are the byte offset. Each line holds a valid flag, a tag and a line of data words. Read hits answer one cycle after acceptance and do not use memory. A read miss stalls the request channel, fetches the whole line, fills it and then returns the requested word.

Stores follow a write-through policy. A store that hits updates its word in the line and is also sent to memory. A store that misses first fetches and fills the line, then merges the word into it, then sends the store to memory. The processor side is a valid/ready request channel:
- A request is taken on a cycle where both `req_valid` and `req_ready` are high.
- While `req_ready` is low, the requester keeps its request and its fields stable. A low `req_ready` is the stall.
- The response is a one-cycle `rsp_valid` pulse. It has no back-pressure, so the requester must take it when it appears.

The memory side is a request/acknowledge pair. `mem_req` stays high, with stable fields, until the memory returns a one-cycle `mem_ack`. For a line fetch, the line is on `mem_rdata` during that acknowledge cycle.

Top module: `dmwt_cache`

## Requirements
- R1: While reset is asserted and right after it, every line is invalid, `req_ready` is high, and `mem_req` and `rsp_valid` are low. As a result, the first access to any address misses.
- R2: The address is split as follows:
  - bits 1:0 are the byte offset and are ignored;
  - bits 3:2 select a 32-bit word of the line, where word w is `line[32w+31:32w]`;
  - the next INDEX_W bits select the line, so the line is the block address modulo the line count;
  - the remaining high bits are the tag.
- R3: A read whose line is valid and whose stored tag matches gives `rsp_valid` with the selected word in the cycle after acceptance, with no memory request.
- R4: On a read miss:
  - from the cycle after acceptance, `req_ready` is low and a fetch is raised (`mem_req`=1, `mem_we`=0, `mem_addr` = request address with bits 3:0 cleared);
  - on `mem_ack` the line is filled from `mem_rdata` and marked valid with the new tag;
  - the requested word comes out with `rsp_valid` in the cycle after the acknowledge.
- R5: On a write hit, the word in the line is updated at acceptance. A memory write (`mem_we`=1, `mem_addr` = request address, `mem_wdata` = request data) is then raised, and `rsp_valid` pulses in the cycle after its acknowledge.
- R6: On a write miss, the line is first fetched as in R4 and filled with the new word merged in. The memory write of R5 then follows, and the response comes only after that write is acknowledged.
- R7: Two addresses with the same index and different tags evict each other, so alternating between them misses every time.
- R8: In the cycle after each accepted request, exactly one of `hit_pulse` and `miss_pulse` is high, giving the lookup outcome. At all other times both are low.
- R9: From the acceptance of a miss or a write until its response, `req_ready` stays low and no new request is taken.
- R10: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the raising of a memory request until its `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request taken this cycle; low means stall |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Load data, valid with rsp_valid on loads |
| hit_pulse | output | 1 | Previous accepted request hit |
| miss_pulse | output | 1 | Previous accepted request missed |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_we | output | 1 | 1 = word write-through, 0 = line fetch |
| mem_addr | output | 32 | Line address (fetch) or byte address (write) |
| mem_wdata | output | 32 | Write-through data |
| mem_rdata | input | 128 | Fetched line, valid with mem_ack |

## Verification
The assertions assume three things about the environment:
- `mem_ack` is raised only while `mem_req` is high, and for one cycle at a time.
- A requester that sees `req_ready` low holds its request fields.
- The response pulse is always consumed.

The stimulus keeps to these rules. Its memory model answers only a pending request, with a latency that cycles from zero to two extra cycles, and drops the acknowledge at the next cycle. Its request task keeps `req_valid` and the fields constant until an edge where `req_ready` was seen high.

// File: rtl/dmwt_pkg.sv
package dmwt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2
  } dmwt_state_e;
endpackage

// File: rtl/dmwt_tag_store.sv
module dmwt_tag_store #(
  parameter int INDEX_W = 12,
  parameter int TAG_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] lk_index,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  input  logic               fill_en,
  input  logic [INDEX_W-1:0] fill_index,
  input  logic [TAG_W-1:0]   fill_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[fill_index] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_index] <= fill_tag;
  end

  assign lk_hit = valid_q[lk_index] && (tag_q[lk_index] == lk_tag);
endmodule

// File: rtl/dmwt_data_store.sv
module dmwt_data_store #(
  parameter int INDEX_W = 12,
  parameter int OFFS_W  = 2,
  parameter int WORD_W  = 32
) (
  input  logic                       clk,
  input  logic [INDEX_W-1:0]         rd_index,
  input  logic [OFFS_W-1:0]          rd_sel,
  output logic [WORD_W-1:0]          rd_word,
  input  logic                       fill_en,
  input  logic [(WORD_W<<OFFS_W)-1:0] fill_line,
  input  logic                       wr_en,
  input  logic [INDEX_W-1:0]         wr_index,
  input  logic [OFFS_W-1:0]          wr_sel,
  input  logic [WORD_W-1:0]          wr_data
);
  localparam int LINES = 1 << INDEX_W;
  localparam int WPL   = 1 << OFFS_W;

  logic [WORD_W-1:0] lane_rd [WPL];

  for (genvar w = 0; w < WPL; w++) begin : g_lane
    logic [WORD_W-1:0] lane_q [LINES];
    // A word write wins over the fill, which merges a store into a fetched line.
    always_ff @(posedge clk) begin
      if (wr_en && (wr_sel == OFFS_W'(w)))
        lane_q[wr_index] <= wr_data;
      else if (fill_en)
        lane_q[wr_index] <= fill_line[w*WORD_W +: WORD_W];
    end
    assign lane_rd[w] = lane_q[rd_index];
  end

  assign rd_word = lane_rd[rd_sel];
endmodule

// File: rtl/dmwt_ctrl.sv
module dmwt_ctrl
  import dmwt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int OFFS_W = 2,
  parameter int BYTE_W = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_we,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [WORD_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  output logic [WORD_W-1:0]           rsp_rdata,
  output logic                        hit_pulse,
  output logic                        miss_pulse,
  input  logic                        lk_hit,
  input  logic [WORD_W-1:0]           rd_word,
  output logic                        fill_en,
  output logic                        wr_en,
  output logic [ADDR_W-1:0]           act_addr,
  output logic [WORD_W-1:0]           act_wdata,
  output logic                        mem_req,
  input  logic                        mem_ack,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [WORD_W-1:0]           mem_wdata,
  input  logic [(WORD_W<<OFFS_W)-1:0] mem_rdata
);
  localparam int LINE_LSB = BYTE_W + OFFS_W;

  dmwt_state_e        state_q;
  logic [ADDR_W-1:0]  cap_addr;
  logic [WORD_W-1:0]  cap_wdata;
  logic               cap_we;
  logic               accept;
  logic [WORD_W-1:0]  fetched_word;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign fetched_word = mem_rdata[int'(cap_addr[BYTE_W +: OFFS_W]) * WORD_W +: WORD_W];

  assign fill_en   = (state_q == ST_FETCH) && mem_ack;
  assign wr_en     = (accept && req_we && lk_hit) || (fill_en && cap_we);
  assign act_addr  = req_ready ? req_addr  : cap_addr;
  assign act_wdata = req_ready ? req_wdata : cap_wdata;

  assign mem_req   = (state_q != ST_IDLE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_wdata = cap_wdata;
  assign mem_addr  = (state_q == ST_WRITE) ? cap_addr
                   : {cap_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cap_addr   <= '0;
      cap_wdata  <= '0;
      cap_we     <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      hit_pulse  <= 1'b0;
      miss_pulse <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      hit_pulse  <= 1'b0;
      miss_pulse <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          cap_addr   <= req_addr;
          cap_wdata  <= req_wdata;
          cap_we     <= req_we;
          hit_pulse  <= lk_hit;
          miss_pulse <= !lk_hit;
          if (!lk_hit)     state_q <= ST_FETCH;
          else if (req_we) state_q <= ST_WRITE;
          else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= rd_word;
          end
        end
        ST_FETCH: if (mem_ack) begin
          if (cap_we) state_q <= ST_WRITE;
          else begin
            state_q   <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= fetched_word;
          end
        end
        ST_WRITE: if (mem_ack) begin
          state_q   <= ST_IDLE;
          rsp_valid <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_read_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_we && lk_hit |=> rsp_valid && hit_pulse && !mem_req);
  p_miss_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lk_hit |=> mem_req && !mem_we && !req_ready && miss_pulse);
  p_write_thru_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_we && lk_hit |=> mem_req && mem_we && !rsp_valid);
  p_wmiss_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en && cap_we |=> mem_req && mem_we && !rsp_valid);
  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_pulse, miss_pulse}));
  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !req_ready && !rsp_valid);
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
endmodule

// File: rtl/dmwt_cache.sv
module dmwt_cache #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int OFFS_W  = 2,
  parameter int INDEX_W = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_we,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [WORD_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  output logic [WORD_W-1:0]           rsp_rdata,
  output logic                        hit_pulse,
  output logic                        miss_pulse,
  output logic                        mem_req,
  input  logic                        mem_ack,
  output logic                        mem_we,
  output logic [ADDR_W-1:0]           mem_addr,
  output logic [WORD_W-1:0]           mem_wdata,
  input  logic [(WORD_W<<OFFS_W)-1:0] mem_rdata
);
  localparam int BYTE_W   = $clog2(WORD_W / 8);
  localparam int LINE_LSB = BYTE_W + OFFS_W;
  localparam int TAG_W    = ADDR_W - LINE_LSB - INDEX_W;

  logic              lk_hit, fill_en, wr_en;
  logic [WORD_W-1:0] rd_word, act_wdata;
  logic [ADDR_W-1:0] act_addr;

  dmwt_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFFS_W(OFFS_W), .BYTE_W(BYTE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
    .lk_hit(lk_hit), .rd_word(rd_word),
    .fill_en(fill_en), .wr_en(wr_en), .act_addr(act_addr), .act_wdata(act_wdata),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  dmwt_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_index(req_addr[LINE_LSB +: INDEX_W]),
    .lk_tag(req_addr[ADDR_W-1 -: TAG_W]),
    .lk_hit(lk_hit),
    .fill_en(fill_en),
    .fill_index(act_addr[LINE_LSB +: INDEX_W]),
    .fill_tag(act_addr[ADDR_W-1 -: TAG_W])
  );

  dmwt_data_store #(.INDEX_W(INDEX_W), .OFFS_W(OFFS_W), .WORD_W(WORD_W)) u_data (
    .clk(clk),
    .rd_index(req_addr[LINE_LSB +: INDEX_W]),
    .rd_sel(req_addr[BYTE_W +: OFFS_W]),
    .rd_word(rd_word),
    .fill_en(fill_en), .fill_line(mem_rdata),
    .wr_en(wr_en),
    .wr_index(act_addr[LINE_LSB +: INDEX_W]),
    .wr_sel(act_addr[BYTE_W +: OFFS_W]),
    .wr_data(act_wdata)
  );
endmodule

// File: tb/dmwt_cache_tb_top.sv
module dmwt_cache_tb_top;
  localparam int IW = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_we, req_ready;
  logic [31:0]  req_addr, req_wdata;
  logic         rsp_valid, hit_pulse, miss_pulse;
  logic [31:0]  rsp_rdata;
  logic         mem_req, mem_we;
  logic         mem_ack = 1'b0;
  logic [31:0]  mem_addr, mem_wdata;
  logic [127:0] mem_rdata = '0;

  always #5 clk = ~clk;

  dmwt_cache #(.INDEX_W(IW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .hit_pulse(hit_pulse), .miss_pulse(miss_pulse),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // Behavioural lower-level memory
  logic [31:0] mem_m [logic [31:0]];
  function automatic logic [31:0] mem_rd(input logic [31:0] wa);
    if (mem_m.exists(wa)) return mem_m[wa];
    return (wa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  int          fetches = 0, writes = 0, lat_cnt = 0, lat_tgt = 0, lat_seed = 0;
  logic [31:0] last_fetch, last_waddr, last_wdata;
  bit          pend = 0;
  logic [31:0] p_addr, p_wdata;
  logic        p_we;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      pend = 0;
    end else if (rst_n && mem_req) begin
      check(!req_ready, "R9 stall during memory request", {31'd0, req_ready}, 32'd0);
      if (pend) begin
        check(mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata,
              "R10 memory request stable", mem_addr, p_addr);
      end
      pend = 1; p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
      if (lat_cnt >= lat_tgt) begin
        mem_ack = 1'b1;
        if (!mem_we) begin
          fetches++;
          last_fetch = mem_addr;
          for (int w = 0; w < 4; w++) mem_rdata[w*32 +: 32] = mem_rd(mem_addr + 32'(w*4));
        end else begin
          writes++;
          last_waddr = mem_addr;
          last_wdata = mem_wdata;
          mem_m[{mem_addr[31:2], 2'b00}] = mem_wdata;
        end
        lat_seed++;
        lat_tgt = lat_seed % 3;
        lat_cnt = 0;
      end else lat_cnt++;
    end
  end

  int hits_seen = 0, miss_seen = 0;
  always @(negedge clk) begin
    if (hit_pulse)  hits_seen++;
    if (miss_pulse) miss_seen++;
  end

  // Reference line model: valid flags and tags only
  bit          ref_v [1 << IW];
  logic [31:0] ref_t [1 << IW];
  int          exp_hits = 0, exp_miss = 0;

  task automatic access(input bit we, input logic [31:0] addr, input logic [31:0] wd);
    int          idx;
    logic [31:0] tg;
    bit          exp_hit, acc;
    logic        rdy;
    int          cyc;
    string       rq;
    idx = int'(addr[4 +: IW]);
    tg  = addr >> (4 + IW);
    exp_hit = ref_v[idx] && ref_t[idx] == tg;
    if (exp_hit) exp_hits++; else exp_miss++;
    fetches = 0; writes = 0;
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = wd;
    acc = 0; cyc = 0;
    while (!acc && cyc < 100) begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) acc = 1;
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    check({hit_pulse, miss_pulse} == {exp_hit, !exp_hit}, "R8 lookup outcome",
          {30'd0, hit_pulse, miss_pulse}, {30'd0, exp_hit, !exp_hit});
    cyc = 0;
    while (!rsp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    check(rsp_valid, "R9 response arrives", {31'd0, rsp_valid}, 32'd1);
    ref_v[idx] = 1; ref_t[idx] = tg;
    if (!we) begin
      rq = exp_hit ? "R3 read hit data" : "R4 read miss data";
      check(rsp_rdata == mem_rd({addr[31:2], 2'b00}), rq, rsp_rdata, mem_rd({addr[31:2], 2'b00}));
      check(writes == 0, "R3 no write on read", writes, 0);
    end else begin
      rq = exp_hit ? "R5 write-through" : "R6 write-miss write-through";
      check(writes == 1 && last_waddr == addr && last_wdata == wd, rq, last_wdata, wd);
    end
    check(fetches == (exp_hit ? 0 : 1), exp_hit ? "R3 no fetch on hit" : "R4 one fetch", fetches, exp_hit ? 0 : 1);
    if (!exp_hit)
      check(last_fetch == {addr[31:4], 4'h0}, "R4 fetch address aligned", last_fetch, {addr[31:4], 4'h0});
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 0);
    report();
  end

  initial begin
    logic [31:0] lcg;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", {31'd0, req_ready}, 32'd1);
    check(!mem_req && !rsp_valid, "R1 idle outputs in reset", {30'd0, mem_req, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !mem_req, "R1 idle after reset", {30'd0, req_ready, mem_req}, 32'd2);

    access(0, 32'h0000_0100, 0);            // R1: first access misses
    access(0, 32'h0000_0104, 0);            // R2: word select, same line hits
    access(0, 32'h0000_0108, 0);
    access(0, 32'h0000_010C, 0);
    access(0, 32'h0000_010B, 0);            // R2: byte offset ignored
    access(1, 32'h0000_0104, 32'hCAFE_0001); // R5
    access(0, 32'h0000_0104, 0);            // R5: line updated
    access(1, 32'h0000_0232, 32'hBEEF_0002); // R6 with byte offset
    access(0, 32'h0000_0230, 0);            // R6: merged word hits
    access(0, 32'h0000_0234, 0);            // R6: rest of line from memory
    access(0, 32'h0000_1100, 0);            // R7: same index, new tag
    access(0, 32'h0000_0100, 0);            // R7: evicted, misses again
    access(0, 32'h0000_1104, 0);            // R7: misses again
    access(0, 32'h0000_0104, 0);            // R7: miss, written value from memory

    lcg = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      access(lcg[31], {20'd0, lcg[19:8]} ^ {30'd0, lcg[3:2]}, lcg ^ 32'h0F0F_A5A5);
    end

    check(hits_seen == exp_hits, "R8 total hits", hits_seen, exp_hits);
    check(miss_seen == exp_miss, "R8 total misses", miss_seen, exp_miss);
    report();
  end
endmodule